// File: doc/BRIEF.md
# Multi-Channel Event Timer

This block keeps a free-running 64-bit tick counter and three comparator channels that watch it. Software reaches every control and status field through a word-wide register port: one write strobe, a byte address and 64 bits of write data. Reads return on the same port with no added latency. When the counter reaches a channel's comparator value, that channel raises an interrupt. The interrupt is either a one-cycle pulse or a level that software clears, and it is steered onto one of 32 output lines.

A channel can fire once, or it can fire periodically. In periodic mode a period is latched through an arming step, and the comparator advances by that period on every hit. A global override sends channel 0 to line 2 and channel 1 to line 8, whatever their own routing fields say. A read-only capability word reports the tick length in femtoseconds, an identifier, and the number of channels.

Top module: `evt_timer`

## Requirements
- R1: The word at byte offset 0x000 reads tick period (fs) in bits 63:32, identifier in 31:16, bit 15 = 1 (fixed-line override present), bit 13 = 1 (64-bit counter), bits 12:8 = index of the last channel (2). Writes to it are ignored.
- R2: After reset the counter (offset 0x0F0) reads zero. It increments by one per clock while bit 0 of the global control word (offset 0x010) is 1, and holds while that bit is 0.
- R3: A write to the counter is accepted only while the counter is halted. A write while it runs is ignored.
- R4: A one-shot channel (control bit 3 = 0) fires on the cycle the running counter equals its comparator (channel N comparator at 0x108 + 0x20*N), and it does not fire again until the counter next reaches that value.
- R5: Writing a channel's control word (0x100 + 0x20*N) with bit 6 = 1 arms it. A following comparator write in periodic mode loads both comparator and period and then clears bit 6. Each hit of a periodic channel adds the period to the comparator.
- R6: Control bit 4 reads 1 only for channels 0 and 1. Channel 2 ignores writes to bit 3, which reads 0. Bit 5 reads 1 for every channel.
- R7: With control bit 1 = 1 (level) and bit 2 = 1, a hit sets status bit N (offset 0x020) and holds the routed line high. Writing 1 to the status bit clears it and drops the line. Writing 0 has no effect.
- R8: With control bit 1 = 0 (edge) and bit 2 = 1, a hit gives a single-cycle pulse on the routed line and leaves the status bit clear.
- R9: Control bits 13:9 choose the output line. Bits 63:32 are a read-only mask of lines the channel may use (ch0, ch1: lines 20-23; ch2: lines 16 and 20-23). A choice outside the mask drives no line.
- R10: With global control bit 1 = 1, channel 0 drives line 2 and channel 1 drives line 8 instead of their chosen lines.
- R11: Undecoded offsets and unused bits (control bits 0, 7, 8, 31:14; global bits 63:2) read zero, and writes to them have no effect.
- R12: With control bit 2 = 0, a hit neither sets status nor drives any line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe for the addressed word |
| addr_i | input | 12 | Byte address; bits 2:0 ignored |
| wdata_i | input | 64 | Write data |
| rdata_o | output | 64 | Read data for addr_i, combinational |
| irq_o | output | 32 | Interrupt output lines |

## Verification
The checker watches on every cycle that the counter holds or steps according to its run bit, that a status bit clears after a write-one, that edge hits never set status, and that the fixed-line override forwards channels 0 and 1 onto lines 2 and 8. Some behaviour only shows up through the bench's scenarios against its behavioural model. That covers the arming and self-clearing of the period load, the comparator stepping by the period across several hits, a one-shot that stays silent after clearing, masked routing choices that light no line, and unused bits reading back as zero.

// File: rtl/evt_timer_pkg.sv
package evt_timer_pkg;
  localparam int CNT_W   = 64;
  localparam int RT_W    = 5;
  localparam int N_LINE  = 1 << RT_W;
  localparam int WORD_W  = 9;

  // word indices (byte offset >> 3)
  localparam logic [WORD_W-1:0] W_CAP  = 9'h000;
  localparam logic [WORD_W-1:0] W_GCFG = 9'h002;
  localparam logic [WORD_W-1:0] W_STAT = 9'h004;
  localparam logic [WORD_W-1:0] W_CNT  = 9'h01E;
  localparam int                W_CH0  = 'h020;
  localparam int                W_CH_STRIDE = 4;

  // channel control bit positions
  localparam int B_LVL    = 1;
  localparam int B_IE     = 2;
  localparam int B_PER    = 3;
  localparam int B_PERCAP = 4;
  localparam int B_VS     = 6;
  localparam int B_RT     = 9;

  localparam int LEG_LINE0 = 2;
  localparam int LEG_LINE1 = 8;
endpackage

// File: rtl/evt_timer_chan.sv
module evt_timer_chan
  import evt_timer_pkg::*;
#(
  parameter bit          PER_CAP = 1'b1,
  parameter logic [31:0] RT_CAP  = 32'h0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             run_i,
  input  logic             cfg_we_i,
  input  logic             cmp_we_i,
  input  logic [CNT_W-1:0] wdata_i,
  output logic [63:0]      cfg_o,
  output logic [CNT_W-1:0] cmp_o,
  output logic             fire_o,
  output logic             lvl_o,
  output logic             edge_o,
  output logic [RT_W-1:0]  route_o,
  output logic             route_ok_o
);
  logic             lvl_q, ie_q, per_q, vs_q, edge_q;
  logic [RT_W-1:0]  rt_q;
  logic [CNT_W-1:0] cmp_q, prd_q;
  logic             hit;

  assign hit    = run_i && (cnt_i == cmp_q);
  assign fire_o = hit && ie_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q  <= 1'b0;
      ie_q   <= 1'b0;
      per_q  <= 1'b0;
      vs_q   <= 1'b0;
      rt_q   <= '0;
      cmp_q  <= '0;
      prd_q  <= '0;
      edge_q <= 1'b0;
    end else begin
      edge_q <= fire_o && !lvl_q;
      if (cmp_we_i) begin
        cmp_q <= wdata_i;
        if (per_q && vs_q) begin
          prd_q <= wdata_i;
          vs_q  <= 1'b0;
        end
      end else if (hit && per_q) begin
        cmp_q <= cmp_q + prd_q;
      end
      if (cfg_we_i) begin
        lvl_q <= wdata_i[B_LVL];
        ie_q  <= wdata_i[B_IE];
        per_q <= PER_CAP && wdata_i[B_PER];
        vs_q  <= wdata_i[B_VS];
        rt_q  <= wdata_i[B_RT +: RT_W];
      end
    end
  end

  assign cfg_o      = {RT_CAP, 18'b0, rt_q, 2'b0, vs_q, 1'b1, PER_CAP, per_q, ie_q, lvl_q, 1'b0};
  assign cmp_o      = cmp_q;
  assign lvl_o      = lvl_q;
  assign edge_o     = edge_q;
  assign route_o    = rt_q;
  assign route_ok_o = RT_CAP[rt_q];
endmodule

// File: rtl/evt_timer_route.sv
module evt_timer_route
  import evt_timer_pkg::*;
#(
  parameter int N_CH = 3
) (
  input  logic [N_CH-1:0]           raw_i,
  input  logic [N_CH-1:0][RT_W-1:0] route_i,
  input  logic [N_CH-1:0]           ok_i,
  input  logic                      leg_i,
  output logic [N_LINE-1:0]         irq_o
);
  always_comb begin
    irq_o = '0;
    for (int n = 0; n < N_CH; n++) begin
      if (leg_i && n == 0)      irq_o[LEG_LINE0] = irq_o[LEG_LINE0] | raw_i[n];
      else if (leg_i && n == 1) irq_o[LEG_LINE1] = irq_o[LEG_LINE1] | raw_i[n];
      else if (ok_i[n])         irq_o[route_i[n]] = irq_o[route_i[n]] | raw_i[n];
    end
  end
endmodule

// File: rtl/evt_timer.sv
module evt_timer
  import evt_timer_pkg::*;
#(
  parameter int                       N_CH      = 3,
  parameter logic [31:0]              TICK_FS   = 32'd20_000_000,
  parameter logic [15:0]              VENDOR    = 16'h5EC7,
  parameter logic [N_CH-1:0]          PER_MASK  = 3'b011,
  parameter logic [N_CH-1:0][31:0]    ROUTE_CAP = {32'h00F1_0000, 32'h00F0_0000, 32'h00F0_0000}
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [11:0]       addr_i,
  input  logic [63:0]       wdata_i,
  output logic [63:0]       rdata_o,
  output logic [N_LINE-1:0] irq_o
);
  localparam logic [4:0]  LAST_CH = 5'(N_CH - 1);
  localparam logic [63:0] CAP_WORD = {TICK_FS, VENDOR, 1'b1, 1'b0, 1'b1, LAST_CH, 8'h00};

  logic [WORD_W-1:0] word;
  logic              run_q, leg_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [N_CH-1:0]   stat_q;
  logic              wr_gcfg, wr_stat, wr_cnt;

  logic [N_CH-1:0][63:0]      ch_cfg;
  logic [N_CH-1:0][CNT_W-1:0] ch_cmp;
  logic [N_CH-1:0]            ch_fire, ch_lvl, ch_edge, ch_ok, ch_raw;
  logic [N_CH-1:0][RT_W-1:0]  ch_rt;

  assign word    = addr_i[11:3];
  assign wr_gcfg = wr_en_i && word == W_GCFG;
  assign wr_stat = wr_en_i && word == W_STAT;
  assign wr_cnt  = wr_en_i && word == W_CNT;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0;
      leg_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      if (wr_cnt && !run_q) cnt_q <= wdata_i;
      else if (run_q)       cnt_q <= cnt_q + 1'b1;
      if (wr_gcfg) begin
        run_q <= wdata_i[0];
        leg_q <= wdata_i[1];
      end
    end
  end

  for (genvar n = 0; n < N_CH; n++) begin : g_ch
    localparam logic [WORD_W-1:0] CFG_W = WORD_W'(W_CH0 + W_CH_STRIDE * n);
    evt_timer_chan #(
      .PER_CAP (PER_MASK[n]),
      .RT_CAP  (ROUTE_CAP[n])
    ) u_chan (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .cnt_i      (cnt_q),
      .run_i      (run_q),
      .cfg_we_i   (wr_en_i && word == CFG_W),
      .cmp_we_i   (wr_en_i && word == CFG_W + 1'b1),
      .wdata_i    (wdata_i),
      .cfg_o      (ch_cfg[n]),
      .cmp_o      (ch_cmp[n]),
      .fire_o     (ch_fire[n]),
      .lvl_o      (ch_lvl[n]),
      .edge_o     (ch_edge[n]),
      .route_o    (ch_rt[n]),
      .route_ok_o (ch_ok[n])
    );

    // level hit has priority over a same-cycle clear
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                      stat_q[n] <= 1'b0;
      else if (ch_fire[n] && ch_lvl[n]) stat_q[n] <= 1'b1;
      else if (wr_stat && wdata_i[n])   stat_q[n] <= 1'b0;
    end

    assign ch_raw[n] = ch_lvl[n] ? stat_q[n] : ch_edge[n];
  end

  evt_timer_route #(.N_CH(N_CH)) u_route (
    .raw_i   (ch_raw),
    .route_i (ch_rt),
    .ok_i    (ch_ok),
    .leg_i   (leg_q),
    .irq_o   (irq_o)
  );

  always_comb begin
    rdata_o = '0;
    case (word)
      W_CAP:   rdata_o = CAP_WORD;
      W_GCFG:  rdata_o = {62'b0, leg_q, run_q};
      W_STAT:  rdata_o = 64'(stat_q);
      W_CNT:   rdata_o = cnt_q;
      default: begin
        for (int n = 0; n < N_CH; n++) begin
          if (word == WORD_W'(W_CH0 + W_CH_STRIDE * n))     rdata_o = ch_cfg[n];
          if (word == WORD_W'(W_CH0 + W_CH_STRIDE * n + 1)) rdata_o = ch_cmp[n];
        end
      end
    endcase
  end
endmodule

// File: rtl/evt_timer_chk.sv
module evt_timer_chk
  import evt_timer_pkg::*;
#(
  parameter int N_CH = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [11:0]       addr_i,
  input logic [63:0]       wdata_i,
  input logic [N_LINE-1:0] irq_o,
  input logic [CNT_W-1:0]  cnt_q,
  input logic              run_q,
  input logic              leg_q,
  input logic [N_CH-1:0]   stat_q,
  input logic [N_CH-1:0]   ch_fire,
  input logic [N_CH-1:0]   ch_lvl,
  input logic [N_CH-1:0]   ch_raw
);
  logic cnt_wr, stat_wr;
  assign cnt_wr  = wr_en_i && addr_i[11:3] == W_CNT;
  assign stat_wr = wr_en_i && addr_i[11:3] == W_STAT;

  assert_cnt_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_q && !cnt_wr |=> $stable(cnt_q));

  assert_cnt_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q |=> cnt_q == $past(cnt_q) + 1'b1);

  assert_leg_line0_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    leg_q && ch_raw[0] |-> irq_o[LEG_LINE0]);

  assert_leg_line1_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    leg_q && ch_raw[1] |-> irq_o[LEG_LINE1]);

  for (genvar n = 0; n < N_CH; n++) begin : g_a
    assert_w1c_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      stat_wr && wdata_i[n] && !(ch_fire[n] && ch_lvl[n]) |=> !stat_q[n]);

    assert_edge_nostat_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ch_fire[n] && !ch_lvl[n] && !stat_q[n] |=> !stat_q[n]);
  end
endmodule

bind evt_timer evt_timer_chk #(.N_CH(N_CH)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .wr_en_i (wr_en_i),
  .addr_i  (addr_i),
  .wdata_i (wdata_i),
  .irq_o   (irq_o),
  .cnt_q   (cnt_q),
  .run_q   (run_q),
  .leg_q   (leg_q),
  .stat_q  (stat_q),
  .ch_fire (ch_fire),
  .ch_lvl  (ch_lvl),
  .ch_raw  (ch_raw)
);

// File: tb/tb_evt_timer.sv
module tb_evt_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [11:0] addr = '0;
  logic [63:0] wdata = '0;
  logic [63:0] rdata;
  logic [31:0] irq;

  int errors = 0;
  int checks = 0;
  string cur_req = "R2";

  localparam logic [63:0] CAP = 64'h01312D00_5EC7A200;
  logic [31:0] mask [3] = '{32'h00F0_0000, 32'h00F0_0000, 32'h00F1_0000};
  bit          pcap [3] = '{1'b1, 1'b1, 1'b0};

  always #10 clk = ~clk;

  evt_timer dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  // behavioural reference
  logic [63:0] m_cnt, m_cmp [3], m_prd [3];
  bit m_en, m_leg, m_stat [3], m_lvl [3], m_ie [3], m_per [3], m_vs [3], m_edge [3];
  int m_rt [3];

  always @(posedge clk or negedge rst_n) begin : model
    bit hit [3];
    if (!rst_n) begin
      m_cnt = 0; m_en = 0; m_leg = 0;
      for (int n = 0; n < 3; n++) begin
        m_cmp[n] = 0; m_prd[n] = 0; m_stat[n] = 0; m_lvl[n] = 0; m_ie[n] = 0;
        m_per[n] = 0; m_vs[n] = 0; m_edge[n] = 0; m_rt[n] = 0;
      end
    end else begin
      for (int n = 0; n < 3; n++) hit[n] = m_en && (m_cnt == m_cmp[n]);
      if (wr_en && addr == 12'h0F0 && !m_en) m_cnt = wdata;
      else if (m_en) m_cnt = m_cnt + 1;
      for (int n = 0; n < 3; n++) begin
        m_edge[n] = hit[n] && m_ie[n] && !m_lvl[n];
        if (hit[n] && m_ie[n] && m_lvl[n]) m_stat[n] = 1;
        else if (wr_en && addr == 12'h020 && wdata[n]) m_stat[n] = 0;
        if (wr_en && addr == 12'(264 + 32 * n)) begin
          m_cmp[n] = wdata;
          if (m_per[n] && m_vs[n]) begin m_prd[n] = wdata; m_vs[n] = 0; end
        end else if (hit[n] && m_per[n]) m_cmp[n] = m_cmp[n] + m_prd[n];
        if (wr_en && addr == 12'(256 + 32 * n)) begin
          m_lvl[n] = wdata[1]; m_ie[n] = wdata[2];
          m_per[n] = pcap[n] && wdata[3]; m_vs[n] = wdata[6];
          m_rt[n] = int'(wdata[13:9]);
        end
      end
      if (wr_en && addr == 12'h010) begin m_en = wdata[0]; m_leg = wdata[1]; end
    end
  end

  function automatic logic [31:0] exp_irq();
    logic [31:0] v = '0;
    for (int n = 0; n < 3; n++) begin
      bit r = m_lvl[n] ? m_stat[n] : m_edge[n];
      if (m_leg && n == 0) v[2] |= r;
      else if (m_leg && n == 1) v[8] |= r;
      else if (mask[n][m_rt[n]]) v[m_rt[n]] |= r;
    end
    return v;
  endfunction

  function automatic logic [63:0] exp_rd(logic [11:0] a);
    logic [11:0] b = {a[11:3], 3'b000};
    if (b == 12'h000) return CAP;
    if (b == 12'h010) return {62'b0, m_leg, m_en};
    if (b == 12'h020) return {61'b0, m_stat[2], m_stat[1], m_stat[0]};
    if (b == 12'h0F0) return m_cnt;
    for (int n = 0; n < 3; n++) begin
      if (b == 12'(256 + 32 * n))
        return {mask[n], 18'b0, 5'(m_rt[n]), 2'b0, m_vs[n], 1'b1, pcap[n], m_per[n], m_ie[n], m_lvl[n], 1'b0};
      if (b == 12'(264 + 32 * n)) return m_cmp[n];
    end
    return 64'h0;
  endfunction

  always @(negedge clk) if (rst_n) begin
    checks++;
    if (irq !== exp_irq() || rdata !== exp_rd(addr)) begin
      errors++;
      $display("FAIL %s cycle compare: irq=%h/%h rdata=%h expected irq=%h rdata=%h",
               cur_req, irq, rdata, exp_irq(), exp_rd(addr), exp_rd(addr));
    end
  end

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // all tasks start and end at posedge+2
  task automatic wr(logic [11:0] a, logic [63:0] d);
    wr_en = 1; addr = a; wdata = d;
    @(posedge clk); #2;
    wr_en = 0;
  endtask

  task automatic rd(string req, logic [11:0] a, logic [63:0] exp);
    addr = a;
    @(negedge clk);
    chk(req, rdata, exp);
    @(posedge clk); #2;
  endtask

  task automatic idle(int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic count_line(int n, int line, output int c);
    c = 0;
    repeat (n) begin @(negedge clk); if (irq[line]) c++; end
    @(posedge clk); #2;
  endtask

  task automatic count_any(int n, output int c);
    c = 0;
    repeat (n) begin @(negedge clk); if (irq != 0) c++; end
    @(posedge clk); #2;
  endtask

  task automatic arm(logic [63:0] cnt_v);
    wr(12'h010, 64'h0);
    wr(12'h0F0, cnt_v);
  endtask

  task automatic finish_run();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    int c;
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    @(posedge clk); #2;

    cur_req = "R1";
    rd("R1 capability word", 12'h000, CAP);
    cur_req = "R2";
    rd("R2 counter reset", 12'h0F0, 64'h0);
    rd("R2 global control reset", 12'h010, 64'h0);
    wr(12'h010, 64'h1);
    idle(5);
    wr(12'h010, 64'h0);
    rd("R2 counter after run", 12'h0F0, m_cnt);
    chk("R2 counter advanced", 64'(m_cnt != 0), 64'h1);
    idle(4);
    rd("R2 counter held", 12'h0F0, m_cnt);

    cur_req = "R3";
    wr(12'h0F0, 64'h1234);
    rd("R3 write while halted", 12'h0F0, 64'h1234);
    wr(12'h010, 64'h1);
    wr(12'h0F0, 64'h0);
    wr(12'h010, 64'h0);
    chk("R3 write while running ignored", 64'(m_cnt > 64'h1234), 64'h1);
    rd("R3 counter readback", 12'h0F0, m_cnt);

    cur_req = "R11";
    wr(12'h008, '1);
    rd("R11 reserved offset", 12'h008, 64'h0);
    wr(12'h0F8, '1);
    rd("R11 reserved offset high", 12'h0F8, 64'h0);
    wr(12'h000, 64'h0);
    rd("R1 capability not writable", 12'h000, CAP);
    wr(12'h010, 64'hFFFF_FFFF_FFFF_FFFC);
    rd("R11 global unused bits", 12'h010, 64'h0);
    wr(12'h120, 64'hFFFF_FFFF_0000_0181);
    rd("R11 channel unused bits", 12'h120, 64'h00F00000_00000030);

    cur_req = "R4";
    wr(12'h100, 64'h2806);
    rd("R9 channel 0 control", 12'h100, 64'h00F00000_00002836);
    arm(64'd100);
    wr(12'h108, 64'd110);
    wr(12'h010, 64'h1);
    idle(20);
    rd("R4 level hit sets status", 12'h020, 64'h1);
    chk("R7 line 20 held", 64'(irq[20]), 64'h1);
    cur_req = "R7";
    wr(12'h020, 64'h0);
    rd("R7 write zero no effect", 12'h020, 64'h1);
    wr(12'h020, 64'h1);
    rd("R7 write one clears", 12'h020, 64'h0);
    chk("R7 line dropped", 64'(irq[20]), 64'h0);
    cur_req = "R4";
    idle(20);
    rd("R4 one-shot silent after", 12'h020, 64'h0);

    cur_req = "R8";
    wr(12'h100, 64'h0);
    wr(12'h120, 64'h2A04);
    arm(64'd200);
    wr(12'h128, 64'd205);
    wr(12'h010, 64'h1);
    count_line(20, 21, c);
    chk("R8 single pulse on line 21", 64'(c), 64'd1);
    rd("R8 status stays clear", 12'h020, 64'h0);

    cur_req = "R5";
    wr(12'h120, 64'h0);
    arm(64'd0);
    wr(12'h100, 64'h2C4C);
    wr(12'h108, 64'd4);
    rd("R5 arm bit self-clears", 12'h100, 64'h00F00000_00002C3C);
    wr(12'h010, 64'h1);
    count_line(40, 22, c);
    chk("R5 periodic pulse count", 64'(c), 64'd9);
    wr(12'h010, 64'h0);
    rd("R5 comparator stepped", 12'h108, m_cmp[0]);
    chk("R5 comparator multiple of period", 64'(m_cmp[0] % 4), 64'd0);
    wr(12'h100, 64'h0);

    cur_req = "R6";
    wr(12'h140, 64'h8);
    rd("R6 channel 2 rejects periodic", 12'h140, 64'h00F10000_00000020);

    cur_req = "R9";
    wr(12'h140, 64'h2004);
    arm(64'd300);
    wr(12'h148, 64'd303);
    wr(12'h010, 64'h1);
    count_line(10, 16, c);
    chk("R9 allowed line 16 pulses", 64'(c), 64'd1);
    wr(12'h140, 64'h2204);
    arm(64'd400);
    wr(12'h148, 64'd403);
    wr(12'h010, 64'h1);
    count_any(10, c);
    chk("R9 masked line drives nothing", 64'(c), 64'd0);
    wr(12'h140, 64'h0);

    cur_req = "R10";
    wr(12'h010, 64'h2);
    wr(12'h0F0, 64'd500);
    wr(12'h100, 64'h2806);
    wr(12'h120, 64'h2A04);
    wr(12'h108, 64'd505);
    wr(12'h128, 64'd507);
    wr(12'h010, 64'h3);
    count_line(20, 8, c);
    chk("R10 channel 1 pulse on line 8", 64'(c), 64'd1);
    chk("R10 channel 0 on line 2", 64'(irq[2]), 64'h1);
    chk("R10 chosen lines idle", 64'(irq[21:20]), 64'h0);
    wr(12'h020, 64'h7);
    wr(12'h010, 64'h0);

    cur_req = "R12";
    wr(12'h120, 64'h0);
    wr(12'h100, 64'h2802);
    arm(64'd600);
    wr(12'h108, 64'd605);
    wr(12'h010, 64'h1);
    count_any(15, c);
    chk("R12 disabled channel no line", 64'(c), 64'd0);
    rd("R12 disabled channel no status", 12'h020, 64'h0);

    finish_run();
  end
endmodule